// File: doc/BRIEF.md
# Pull-Resistor Configuration Latch

This block holds the pull-resistor setting of every pin in a GPIO bank group. Pins are never configured individually. Software first writes a single shared mode register with off, pull-down or pull-up. It then raises the pins' bits in a per-bank strobe register, and finally lowers them again. Each pin whose strobe bit falls stores the shared mode, but only when two timing rules were met. The mode must have been stable for a minimum number of cycles before the strobe rose. The strobe must then have stayed high for a minimum number of cycles.

A sequence that breaks either rule leaves the pin's stored setting untouched and sets a sticky error flag. Several pins can be configured in one sequence by raising several strobe bits together. Each pin drives a pull-enable and a pull-direction output toward the pad resistors. Only reset clears the error flag.

Top module: `pull_cfg_latch`

## Requirements
- R1: After reset every pin is off (pull_en_o and pull_up_o all 0) and err_o is 0; reset also counts as the last change of the shared mode.
- R2: Mode encoding on mode_i is 0 = off, 1 = pull-down, 2 = pull-up. A stored off drives en=0/up=0, pull-down drives en=1/up=0, and pull-up drives en=1/up=1.
- R3: A pin stores the shared mode when its strobe bit falls, provided that at least SETUP_CYC cycles separate the last mode-changing write from the rise write, at least HOLD_CYC cycles separate the rise write from the fall write, and the mode does not change from the rise through the fall. The outputs update the cycle after the fall write.
- R4: A strobe write loads all BANK_PINS bits of the bank on strb_bank_i at once. Bit b of bank k addresses pin k*BANK_PINS+b. Bits that address no existing pin are ignored, and pins of other banks are not touched.
- R5: Several pins raised and lowered in one sequence all store the same mode.
- R6: A rise that comes fewer than SETUP_CYC cycles after a mode change, including a change in the same cycle, leaves the pin unchanged at its fall and sets err_o.
- R7: A fall that comes fewer than HOLD_CYC cycles after the rise leaves the pin unchanged and sets err_o.
- R8: A mode change while a pin's strobe is high, including in the fall cycle, makes that pin's sequence fail: the pin is unchanged and err_o is set.
- R9: A correctly timed sequence with the reserved mode 3 leaves the pin unchanged and does not set err_o.
- R10: Once set, err_o stays 1 until reset.
- R11: Pin outputs change only in the cycle after a strobe write. Mode writes alone never change them.
- R12: Writing the mode register with its current value is not a change and does not restart the setup window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_we_i | input | 1 | Write strobe for the shared mode register |
| mode_i | input | 2 | Mode value to write |
| strb_we_i | input | 1 | Write strobe for a bank's strobe register |
| strb_bank_i | input | BANK_W | Bank selected by a strobe write |
| strb_bits_i | input | BANK_PINS | New strobe register contents for that bank |
| pull_en_o | output | NPINS | Per-pin pull enable |
| pull_up_o | output | NPINS | Per-pin pull direction (1 = up) |
| err_o | output | 1 | Sticky timing-violation flag |

## Verification
The hardest cases to reach from the ports are the exact edges of the two timing windows. A strobe exactly SETUP_CYC or HOLD_CYC cycles after its reference write must pass, and one cycle fewer must fail. The stimulus tasks each consume a known number of clock edges, so the bench places writes on exact edge numbers and runs both sides of each boundary. Because the error flag is sticky, each violation scenario starts from a fresh reset. The bench also rewrites an unchanged mode value inside the setup window, to show that the window is not restarted.

// File: rtl/pull_cfg_pkg.sv
package pull_cfg_pkg;
  typedef enum logic [1:0] {
    PULL_OFF  = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_UP   = 2'd2,
    PULL_RSVD = 2'd3
  } pull_mode_e;
endpackage

// File: rtl/pull_mode_track.sv
module pull_mode_track
  import pull_cfg_pkg::*;
#(
  parameter int SETUP_CYC = 150
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  pull_mode_e mode_i,
  output pull_mode_e mode_o,
  output logic       chg_o,
  output logic       setup_ok_o
);
  localparam int SCNT_W = $clog2(SETUP_CYC + 1) + 1;

  pull_mode_e        mode_q;
  logic [SCNT_W-1:0] scnt_q;

  assign chg_o      = we_i && (mode_i != mode_q);
  assign setup_ok_o = (int'(scnt_q) >= SETUP_CYC) && !chg_o;
  assign mode_o     = mode_q;

  // scnt_q equals the cycles elapsed since the last change, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PULL_OFF;
      scnt_q <= SCNT_W'(1);
    end else if (chg_o) begin
      mode_q <= mode_i;
      scnt_q <= SCNT_W'(1);
    end else if (int'(scnt_q) < SETUP_CYC) begin
      scnt_q <= scnt_q + SCNT_W'(1);
    end
  end
endmodule

// File: rtl/pull_pin_cell.sv
module pull_pin_cell
  import pull_cfg_pkg::*;
#(
  parameter int HOLD_CYC = 150
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       bit_i,
  input  pull_mode_e mode_i,
  input  logic       chg_i,
  input  logic       setup_ok_i,
  output pull_mode_e state_o,
  output logic       viol_o
);
  localparam int HCNT_W = $clog2(HOLD_CYC + 1) + 1;

  logic              strb_q;
  logic              bad_q;
  logic [HCNT_W-1:0] hcnt_q;
  pull_mode_e        state_q;
  logic              rise, fall, ok;

  assign rise    = wr_i && bit_i && !strb_q;
  assign fall    = wr_i && !bit_i && strb_q;
  assign ok      = !bad_q && !chg_i && (int'(hcnt_q) >= HOLD_CYC);
  assign viol_o  = fall && !ok;
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q  <= 1'b0;
      bad_q   <= 1'b0;
      hcnt_q  <= '0;
      state_q <= PULL_OFF;
    end else if (rise) begin
      strb_q <= 1'b1;
      hcnt_q <= HCNT_W'(1);
      bad_q  <= !setup_ok_i;
    end else if (fall) begin
      strb_q <= 1'b0;
      if (ok && mode_i != PULL_RSVD) state_q <= mode_i;
    end else if (strb_q) begin
      if (int'(hcnt_q) < HOLD_CYC) hcnt_q <= hcnt_q + HCNT_W'(1);
      if (chg_i) bad_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pull_cfg_latch.sv
module pull_cfg_latch
  import pull_cfg_pkg::*;
#(
  parameter int NPINS     = 54,
  parameter int BANK_PINS = 32,
  parameter int SETUP_CYC = 150,
  parameter int HOLD_CYC  = 150,
  localparam int NBANK    = (NPINS + BANK_PINS - 1) / BANK_PINS,
  localparam int BANK_W   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_we_i,
  input  logic [1:0]           mode_i,
  input  logic                 strb_we_i,
  input  logic [BANK_W-1:0]    strb_bank_i,
  input  logic [BANK_PINS-1:0] strb_bits_i,
  output logic [NPINS-1:0]     pull_en_o,
  output logic [NPINS-1:0]     pull_up_o,
  output logic                 err_o
);
  pull_mode_e       mode_cur;
  logic             mode_chg, setup_ok;
  logic [NPINS-1:0] viol;
  logic             err_q;

  pull_mode_track #(.SETUP_CYC(SETUP_CYC)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (mode_we_i),
    .mode_i     (pull_mode_e'(mode_i)),
    .mode_o     (mode_cur),
    .chg_o      (mode_chg),
    .setup_ok_o (setup_ok)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int BANK = p / BANK_PINS;
    localparam int BIT  = p % BANK_PINS;
    pull_mode_e st;
    logic       wr;

    assign wr = strb_we_i && (strb_bank_i == BANK_W'(BANK));

    pull_pin_cell #(.HOLD_CYC(HOLD_CYC)) u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr),
      .bit_i      (strb_bits_i[BIT]),
      .mode_i     (mode_cur),
      .chg_i      (mode_chg),
      .setup_ok_i (setup_ok),
      .state_o    (st),
      .viol_o     (viol[p])
    );

    assign pull_en_o[p] = (st != PULL_OFF);
    assign pull_up_o[p] = (st == PULL_UP);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (|viol) err_q <= 1'b1;
  end

  assign err_o = err_q;
endmodule

// File: rtl/pull_cfg_latch_chk.sv
module pull_cfg_latch_chk #(
  parameter int NPINS = 54
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             strb_we_i,
  input logic [NPINS-1:0] pull_en_o,
  input logic [NPINS-1:0] pull_up_o,
  input logic             err_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (pull_en_o == '0 && pull_up_o == '0 && !err_o));

  // R2
  up_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_up_o & ~pull_en_o) == '0);

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R6
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_we_i && !err_o) |=> !err_o);

  // R11
  pins_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strb_we_i |=> ($stable(pull_en_o) && $stable(pull_up_o)));
endmodule

bind pull_cfg_latch pull_cfg_latch_chk #(.NPINS(NPINS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .strb_we_i (strb_we_i),
  .pull_en_o (pull_en_o),
  .pull_up_o (pull_up_o),
  .err_o     (err_o)
);

// File: tb/pull_cfg_latch_bench.sv
module pull_cfg_latch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 40;
  localparam int BP = 32;
  localparam int SU = 12;
  localparam int HO = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_we = 1'b0;
  logic [1:0]    mode_v = 2'd0;
  logic          strb_we = 1'b0;
  logic [0:0]    strb_bank = 1'b0;
  logic [BP-1:0] strb_bits = '0;
  logic [NP-1:0] pull_en, pull_up;
  logic          err;

  int    n_chk = 0, n_fail = 0;
  bit    run = 0;
  string cur_req = "R1";

  pull_cfg_latch #(.NPINS(NP), .BANK_PINS(BP), .SETUP_CYC(SU), .HOLD_CYC(HO))
    u_pull_cfg_latch (
      .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_i(mode_v),
      .strb_we_i(strb_we), .strb_bank_i(strb_bank), .strb_bits_i(strb_bits),
      .pull_en_o(pull_en), .pull_up_o(pull_up), .err_o(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model: cycle stamps, no counters
  int cyc, mchg, m_mode;
  int m_st[NP];
  int m_rc[NP];
  bit m_hi[NP], m_bad[NP];
  bit m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; mchg = 0; m_mode = 0; m_err = 0;
      for (int p = 0; p < NP; p++) begin
        m_st[p] = 0; m_rc[p] = 0; m_hi[p] = 0; m_bad[p] = 0;
      end
    end else begin
      bit chg;
      cyc++;
      chg = mode_we && (int'(mode_v) != m_mode);
      for (int p = 0; p < NP; p++) begin
        bit hit, b;
        hit = strb_we && (p / BP == int'(strb_bank));
        b   = strb_bits[p % BP];
        if (hit && b && !m_hi[p]) begin
          m_hi[p] = 1; m_rc[p] = cyc;
          m_bad[p] = chg || (cyc - mchg < SU);
        end else if (hit && !b && m_hi[p]) begin
          m_hi[p] = 0;
          if (!m_bad[p] && !chg && (cyc - m_rc[p] >= HO)) begin
            if (m_mode != 3) m_st[p] = m_mode;
          end else m_err = 1;
        end else if (m_hi[p] && chg) m_bad[p] = 1;
      end
      if (chg) begin m_mode = int'(mode_v); mchg = cyc; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && run) begin
      bit bad_cyc;
      bad_cyc = (err !== m_err);
      for (int p = 0; p < NP; p++)
        if (pull_en[p] !== (m_st[p] != 0) || pull_up[p] !== (m_st[p] == 2)) bad_cyc = 1;
      n_chk++;
      if (bad_cyc) begin
        n_fail++;
        $display("FAIL %s cycle %0d: en=%h up=%h err=%b vs model err=%b",
                 cur_req, cyc, pull_en, pull_up, err, m_err);
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected state: 0 off, 1 down, 2 up
  task automatic chk_pin(string req, int p, int exp);
    chk(req, $sformatf("pin %0d", p), {30'd0, pull_up[p], pull_en[p]},
        (exp == 0) ? 0 : (exp == 1) ? 1 : 3);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_mode(int m);
    mode_we = 1'b1; mode_v = 2'(m);
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic strobe(int bank, logic [BP-1:0] bits);
    strb_we = 1'b1; strb_bank = 1'(bank); strb_bits = bits;
    @(negedge clk);
    strb_we = 1'b0;
  endtask

  task automatic seq(int bank, logic [BP-1:0] bits, int m, int su_idle, int ho_idle);
    set_mode(m);
    idle(su_idle);
    strobe(bank, bits);
    idle(ho_idle);
    strobe(bank, '0);
    idle(2);
    set_mode(0);
    idle(2);
  endtask

  task automatic do_reset();
    run = 0;
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    run = 1;
    idle(2);
  endtask

  initial begin
    idle(2);
    do_reset();
    cur_req = "R1";
    chk_pin("R1", 0, 0); chk_pin("R1", 39, 0); chk("R1", "err", int'(err), 0);
    idle(SU);

    cur_req = "R3";
    seq(0, 32'h8, 1, SU - 1, HO - 1);
    chk_pin("R3", 3, 1); chk_pin("R2", 2, 0); chk("R3", "err", int'(err), 0);

    cur_req = "R4";
    seq(1, 32'h10A1, 2, SU - 1, HO - 1);
    chk_pin("R4", 32, 2); chk_pin("R5", 37, 2); chk_pin("R5", 39, 2);
    chk_pin("R4", 5, 0); chk_pin("R4", 3, 1); chk_pin("R4", 33, 0);

    cur_req = "R12";
    set_mode(1); idle(SU - 2); set_mode(1);
    strobe(0, 32'h10); idle(HO - 1); strobe(0, '0); idle(2);
    set_mode(0); idle(2);
    chk_pin("R12", 4, 1); chk("R12", "err", int'(err), 0);

    cur_req = "R9";
    seq(0, 32'h8, 3, SU - 1, HO - 1);
    chk_pin("R9", 3, 1); chk("R9", "err", int'(err), 0);

    cur_req = "R2";
    seq(0, 32'h8, 0, SU - 1, HO - 1);
    chk_pin("R2", 3, 0); chk_pin("R2", 4, 1);

    cur_req = "R6";
    do_reset(); idle(SU);
    seq(0, 32'h2, 2, SU - 2, HO - 1);
    chk_pin("R6", 1, 0); chk("R6", "err", int'(err), 1);
    cur_req = "R10";
    idle(20);
    chk("R10", "err", int'(err), 1);

    cur_req = "R7";
    do_reset(); idle(SU);
    seq(0, 32'h4, 2, SU - 1, HO - 2);
    chk_pin("R7", 2, 0); chk("R7", "err", int'(err), 1);

    cur_req = "R8";
    do_reset(); idle(SU);
    set_mode(2); idle(SU - 1);
    strobe(0, 32'h40); idle(3); set_mode(1); idle(HO); strobe(0, '0); idle(2);
    chk_pin("R8", 6, 0); chk("R8", "err", int'(err), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule